// File: doc/BRIEF.md
# SDRAM Start-up and Refresh Sequencer

This block owns the command pins of a single data rate SDRAM whenever no read or write is in flight. After reset it brings the device up with a fixed series of commands. First it closes every bank, then it runs eight refresh cycles, and last it loads the mode register with CAS latency 2, sequential addressing, and the burst length and write style chosen on two static inputs. Only after that series, and the recovery gap that follows it, does it tell the access sequencer that it may begin.

In normal operation a down-counter loaded from a programmable interval marks when a refresh is owed. An owed refresh holds off new accesses through the handshake output, and the refresh command goes out on the first cycle in which the bus is idle. However many deadlines pass while the bus is busy, only one refresh is recorded. A request input places the device in self-refresh: the refresh encoding is driven together with a low clock enable. A second input brings it out again, with a run of idle cycles before accesses may resume. Every command is followed by a fixed number of idle cycles before the next one. That number depends on the command and is set by a parameter.

Top module: `sdram_upkeep`

## Requirements
- R1: While rst_n is low the block drives mem_cke high, the idle command ({cs_n,ras_n,cas_n,we_n} = 4'b0111) and host_ready low.
- R2: On the first clock edge after reset is released the block issues the close-all-banks command (4'b0010) with address bit AP_BIT (10) set, and then T_RP idle cycles.
- R3: The close-all-banks command is followed by exactly INIT_REFS (8) refresh commands (4'b0001) with mem_cke high. Each one starts T_RP+1 or T_RFC+1 cycles after the command before it.
- R4: T_RFC+1 cycles after the last start-up refresh the block writes the mode register (4'b0000). The address carries burst length in bits 2:0 (000 for one word, 111 for full page, from mode_full_page), a 0 in bit 3 (sequential), 010 in bits 6:4 (CAS latency 2), and in bit 9 the mode_single_write value (1 selects single writes). All other bits are 0.
- R5: host_ready stays low from reset until T_MRD cycles after the mode-register write, and is high in that cycle.
- R6: With the bus idle, consecutive refresh commands start max(N+2, T_RFC+1) cycles apart, where N is refresh_interval. The first refresh after the mode-register write comes max(N+2, T_MRD+1) cycles after it.
- R7: No refresh is issued on an edge where bus_busy is high. Any number of deadlines that pass during a busy stretch yield exactly one refresh, on the first edge that samples bus_busy low.
- R8: host_ready is low while a refresh is owed and for the T_RFC cycles after a refresh command. It is high again once that gap ends, unless a new refresh is owed.
- R9: When sref_enter is sampled high with the block running, idle and out of its gap, the refresh encoding is driven with mem_cke low on that edge. mem_cke then stays low, no command is issued and no refresh is owed until exit.
- R10: When sref_exit is sampled high in self-refresh, mem_cke goes high on that edge and host_ready stays low for T_XSR cycles. The refresh interval restarts from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_interval | input | IVW | Refresh interval N in clocks |
| mode_full_page | input | 1 | 1: full-page burst in mode register, 0: one word |
| mode_single_write | input | 1 | 1: single writes, 0: burst writes |
| bus_busy | input | 1 | An access currently owns the memory |
| sref_enter | input | 1 | Request to enter self-refresh |
| sref_exit | input | 1 | Request to leave self-refresh |
| host_ready | output | 1 | Accesses may be started |
| refresh_owed | output | 1 | A refresh is pending; hold off new accesses |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | AW | Memory address bus |
| mem_ba | output | BW | Bank address |

## Verification
The bench sweeps all four mode-input combinations and checks the exact cycle and encoding of every start-up command and of the mode word. A wrong bit field or an off-by-one in the refresh count would shift the mode-register write or change its address. A sweep of intervals from 0 to 7 covers both the regime where the interval sets the spacing and the regime where the recovery gap does. A timer that reloads late, or that ignores the gap, shows up as refreshes that are too early or too late. A long busy stretch covers several deadlines, and the bench expects a single refresh on the first idle edge. A design that issued under busy, or queued more than one refresh, would fail here. A self-refresh round trip checks the low clock enable, silence on the pins, the exit recovery and the restarted interval.

// File: rtl/sdr_upkeep_pkg.sv
package sdr_upkeep_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    PH_PALL = 3'd0,
    PH_IREF = 3'd1,
    PH_MRS  = 3'd2,
    PH_RUN  = 3'd3,
    PH_SELF = 3'd4
  } seq_phase_e;

  localparam logic [2:0] BL_ONE  = 3'b000;
  localparam logic [2:0] BL_PAGE = 3'b111;
  localparam logic [2:0] CL_TWO  = 3'b010;

  // Mode register image: burst length, sequential order, CAS latency 2,
  // write style in bit 9.
  function automatic logic [15:0] mode_word(input logic full_page,
                                            input logic single_write);
    logic [15:0] w;
    w      = '0;
    w[2:0] = full_page ? BL_PAGE : BL_ONE;
    w[3]   = 1'b0;
    w[6:4] = CL_TWO;
    w[9]   = single_write;
    return w;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Cycles between the starts of two refreshes on an idle bus.
  function automatic int unsigned ref_spacing(input int unsigned ivl,
                                              input int unsigned gap);
    return max2(ivl + 2, gap + 1);
  endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
  parameter int GW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [GW-1:0] load_val,
  output logic          active
);

  logic [GW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int IVW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           reload,
  input  logic [IVW-1:0] interval,
  output logic           owed,
  output logic           expired
);

  logic [IVW-1:0] cnt;

  assign expired = run && !reload && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      owed <= 1'b0;
    end else if (reload) begin
      cnt  <= interval;
      owed <= 1'b0;
    end else if (run) begin
      if (cnt == '0)
        owed <= 1'b1;
      else
        cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/sdr_pin_stage.sv
module sdr_pin_stage
  import sdr_upkeep_pkg::*;
#(
  parameter int AW = 13,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sdr_cmd_e      cmd_nx,
  input  logic [AW-1:0] addr_nx,
  input  logic [BW-1:0] ba_nx,
  input  logic          cke_nx,
  output logic          cke,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [AW-1:0] addr,
  output logic [BW-1:0] ba
);

  sdr_cmd_e cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_NOP;
      addr  <= '0;
      ba    <= '0;
      cke   <= 1'b1;
    end else begin
      cmd_q <= cmd_nx;
      addr  <= addr_nx;
      ba    <= ba_nx;
      cke   <= cke_nx;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

endmodule

// File: rtl/sdram_upkeep.sv
module sdram_upkeep
  import sdr_upkeep_pkg::*;
#(
  parameter int AW        = 13,
  parameter int BW        = 2,
  parameter int IVW       = 12,
  parameter int AP_BIT    = 10,
  parameter int T_RP      = 2,
  parameter int T_RFC     = 4,
  parameter int T_MRD     = 2,
  parameter int T_XSR     = 6,
  parameter int INIT_REFS = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IVW-1:0] refresh_interval,
  input  logic           mode_full_page,
  input  logic           mode_single_write,
  input  logic           bus_busy,
  input  logic           sref_enter,
  input  logic           sref_exit,
  output logic           host_ready,
  output logic           refresh_owed,
  output logic           mem_cke,
  output logic           mem_cs_n,
  output logic           mem_ras_n,
  output logic           mem_cas_n,
  output logic           mem_we_n,
  output logic [AW-1:0]  mem_addr,
  output logic [BW-1:0]  mem_ba
);

  localparam int GMAX = int'(max2(max2(T_RP, T_RFC), max2(T_MRD, T_XSR)));
  localparam int GW   = $clog2(GMAX + 1);
  localparam int RW   = $clog2(INIT_REFS + 1);

  seq_phase_e    phase;
  logic [RW-1:0] refs_left;

  logic          gap_active;
  logic          gap_load;
  logic [GW-1:0] gap_val;

  sdr_cmd_e      cmd_nx;
  logic [AW-1:0] addr_nx;
  logic [BW-1:0] ba_nx;
  logic          cke_nx;
  logic [AW-1:0] mode_addr;

  // Named events for the checker
  logic run_idle, pre_fire, iref_fire, mrs_fire;
  logic ref_fire, self_fire, wake_fire, timer_reload, seq_done, ivl_expired;

  assign run_idle  = (phase == PH_RUN) && !gap_active && !bus_busy;
  assign pre_fire  = (phase == PH_PALL) && !gap_active;
  assign iref_fire = (phase == PH_IREF) && !gap_active;
  assign mrs_fire  = (phase == PH_MRS) && !gap_active;
  assign self_fire = run_idle && sref_enter;
  assign ref_fire  = run_idle && !sref_enter && refresh_owed;
  assign wake_fire = (phase == PH_SELF) && sref_exit;
  assign seq_done  = (phase == PH_RUN) || (phase == PH_SELF);

  assign timer_reload = ref_fire || mrs_fire || self_fire || wake_fire;
  assign mode_addr    = AW'(mode_word(mode_full_page, mode_single_write));

  sdr_refresh_timer #(.IVW(IVW)) u_ivl (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (phase == PH_RUN),
    .reload   (timer_reload),
    .interval (refresh_interval),
    .owed     (refresh_owed),
    .expired  (ivl_expired)
  );

  sdr_gap_timer #(.GW(GW)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_val),
    .active   (gap_active)
  );

  always_comb begin
    cmd_nx   = CMD_NOP;
    addr_nx  = '0;
    ba_nx    = '0;
    cke_nx   = mem_cke;
    gap_load = 1'b0;
    gap_val  = '0;
    if (pre_fire) begin
      cmd_nx          = CMD_PRE;
      addr_nx[AP_BIT] = 1'b1;
      gap_load        = 1'b1;
      gap_val         = GW'(T_RP);
    end else if (iref_fire || ref_fire) begin
      cmd_nx   = CMD_REF;
      gap_load = 1'b1;
      gap_val  = GW'(T_RFC);
    end else if (mrs_fire) begin
      cmd_nx   = CMD_MRS;
      addr_nx  = mode_addr;
      gap_load = 1'b1;
      gap_val  = GW'(T_MRD);
    end else if (self_fire) begin
      cmd_nx = CMD_REF;
      cke_nx = 1'b0;
    end else if (wake_fire) begin
      cke_nx   = 1'b1;
      gap_load = 1'b1;
      gap_val  = GW'(T_XSR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_PALL;
      refs_left <= '0;
    end else begin
      case (phase)
        PH_PALL:
          if (pre_fire) begin
            phase     <= PH_IREF;
            refs_left <= RW'(INIT_REFS);
          end
        PH_IREF:
          if (iref_fire) begin
            refs_left <= refs_left - 1'b1;
            if (refs_left == RW'(1))
              phase <= PH_MRS;
          end
        PH_MRS:  if (mrs_fire)  phase <= PH_RUN;
        PH_RUN:  if (self_fire) phase <= PH_SELF;
        PH_SELF: if (wake_fire) phase <= PH_RUN;
        default: phase <= PH_PALL;
      endcase
    end
  end

  assign host_ready = (phase == PH_RUN) && !gap_active && !refresh_owed;

  sdr_pin_stage #(.AW(AW), .BW(BW)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_nx  (cmd_nx),
    .addr_nx (addr_nx),
    .ba_nx   (ba_nx),
    .cke_nx  (cke_nx),
    .cke     (mem_cke),
    .cs_n    (mem_cs_n),
    .ras_n   (mem_ras_n),
    .cas_n   (mem_cas_n),
    .we_n    (mem_we_n),
    .addr    (mem_addr),
    .ba      (mem_ba)
  );

endmodule

// File: rtl/sdram_upkeep_chk.sv
module sdram_upkeep_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_busy,
  input logic          host_ready,
  input logic          refresh_owed,
  input logic          mem_cke,
  input logic          mem_cs_n,
  input logic          mem_ras_n,
  input logic          mem_cas_n,
  input logic          mem_we_n,
  input logic [AW-1:0] mem_addr,
  input logic          ref_fire,
  input logic          self_fire,
  input logic          wake_fire,
  input logic          seq_done
);

  logic [3:0] pin_cmd;
  logic is_nop, is_pre, is_ref, is_mrs;

  assign pin_cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
  assign is_nop  = (pin_cmd == 4'b0111);
  assign is_pre  = (pin_cmd == 4'b0010);
  assign is_ref  = (pin_cmd == 4'b0001);
  assign is_mrs  = (pin_cmd == 4'b0000);

  p_pre_only_in_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> !seq_done);

  p_mode_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> (mem_addr[6:4] == 3'b010) && !mem_addr[3] && (mem_addr[8:7] == 2'b00));

  p_ready_after_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> seq_done);

  p_ref_on_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire |=> is_ref && mem_cke);

  p_ref_needs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire |-> !bus_busy);

  p_owed_blocks_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_owed |-> !host_ready);

  p_ready_pins_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> is_nop);

  p_self_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cke) |-> is_ref);

  p_self_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cke && $past(!mem_cke)) |-> is_nop);

  p_single_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ref_fire, self_fire, wake_fire}));

  p_wake_recovery_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_fire |=> mem_cke && !host_ready);

endmodule

bind sdram_upkeep sdram_upkeep_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_busy     (bus_busy),
  .host_ready   (host_ready),
  .refresh_owed (refresh_owed),
  .mem_cke      (mem_cke),
  .mem_cs_n     (mem_cs_n),
  .mem_ras_n    (mem_ras_n),
  .mem_cas_n    (mem_cas_n),
  .mem_we_n     (mem_we_n),
  .mem_addr     (mem_addr),
  .ref_fire     (ref_fire),
  .self_fire    (self_fire),
  .wake_fire    (wake_fire),
  .seq_done     (seq_done)
);

// File: tb/sdram_upkeep_test.sv
module sdram_upkeep_test;

  localparam int AW = 13, BW = 2, IVW = 12;
  localparam int T_RP = 2, T_RFC = 4, T_MRD = 2, T_XSR = 6, INIT_REFS = 8;
  localparam int PRE_AT   = 1;
  localparam int REF0_AT  = PRE_AT + T_RP + 1;
  localparam int MRS_AT   = REF0_AT + INIT_REFS * (T_RFC + 1);
  localparam int READY_AT = MRS_AT + T_MRD;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n = 1'b0;
  logic [IVW-1:0] ivl = '0;
  logic           full_pg = 1'b0, single_wr = 1'b0, busy = 1'b0;
  logic           s_in = 1'b0, s_out = 1'b0;
  logic           host_ready, refresh_owed, mem_cke;
  logic           mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
  logic [AW-1:0]  mem_addr;
  logic [BW-1:0]  mem_ba;

  sdram_upkeep #(.AW(AW), .BW(BW), .IVW(IVW), .T_RP(T_RP), .T_RFC(T_RFC),
                 .T_MRD(T_MRD), .T_XSR(T_XSR), .INIT_REFS(INIT_REFS)) uut (
    .clk(clk), .rst_n(rst_n), .refresh_interval(ivl),
    .mode_full_page(full_pg), .mode_single_write(single_wr),
    .bus_busy(busy), .sref_enter(s_in), .sref_exit(s_out),
    .host_ready(host_ready), .refresh_owed(refresh_owed), .mem_cke(mem_cke),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_ba(mem_ba));

  int cyc = 0;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  int             ev_n = 0;
  int             ev_cyc [64];
  logic [3:0]     ev_cmd [64];
  logic           ev_cke [64];
  logic [AW-1:0]  ev_addr[64];
  logic           rdy_h  [256];
  logic           cke_h  [256];
  int checks = 0, errors = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n && cyc > 0 && cyc < 256) begin
      rdy_h[cyc] = host_ready;
      cke_h[cyc] = mem_cke;
      if ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} != 4'b0111 && ev_n < 64) begin
        ev_cyc[ev_n]  = cyc;
        ev_cmd[ev_n]  = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
        ev_cke[ev_n]  = mem_cke;
        ev_addr[ev_n] = mem_addr;
        ev_n = ev_n + 1;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic int spacing(input int n, input int gap);
    return (n + 2 > gap + 1) ? n + 2 : gap + 1;
  endfunction

  function automatic int find_ev(input int c);
    for (int i = 0; i < ev_n; i++) if (ev_cyc[i] == c) return i;
    return -1;
  endfunction

  function automatic int count_ev(input int lo, input int hi);
    int k = 0;
    for (int i = 0; i < ev_n; i++) if (ev_cyc[i] >= lo && ev_cyc[i] <= hi) k++;
    return k;
  endfunction

  task automatic restart(input int n, input logic fp, input logic sw);
    @(negedge clk);
    rst_n = 1'b0; ivl = IVW'(n); full_pg = fp; single_wr = sw;
    busy = 1'b0; s_in = 1'b0; s_out = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1 cke during reset", int'(mem_cke), 1);
    check("R1 command during reset", int'({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}), 7);
    check("R1 ready during reset", int'(host_ready), 0);
    ev_n = 0;
    for (int i = 0; i < 256; i++) begin rdy_h[i] = 1'b0; cke_h[i] = 1'b1; end
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int idx, r, early, mw;
    // Start-up order and mode word, all mode combinations
    for (int m = 0; m < 4; m++) begin
      restart(200, m[0], m[1]);
      wait_cyc(MRS_AT + 16);
      check("R2 first command is close-all", int'(ev_cmd[0]), 2);
      check("R2 close-all cycle", ev_cyc[0], PRE_AT);
      check("R2 auto-precharge bit", int'(ev_addr[0][10]), 1);
      for (int i = 0; i < INIT_REFS; i++) begin
        check("R3 start-up refresh code", int'(ev_cmd[1 + i]), 1);
        check("R3 start-up refresh cycle", ev_cyc[1 + i], REF0_AT + i * (T_RFC + 1));
      end
      mw = (m[0] ? 7 : 0) + (2 << 4) + (m[1] ? 512 : 0);
      check("R4 mode write code", int'(ev_cmd[1 + INIT_REFS]), 0);
      check("R4 mode write cycle", ev_cyc[1 + INIT_REFS], MRS_AT);
      check("R4 mode word", int'(ev_addr[1 + INIT_REFS]), mw);
      check("R3 command count before interval", ev_n, INIT_REFS + 2);
      early = 0;
      for (int c = 1; c < READY_AT; c++) if (rdy_h[c]) early++;
      check("R5 ready held low during start-up", early, 0);
      check("R5 ready at end of start-up", int'(rdy_h[READY_AT]), 1);
    end

    // Interval sweep on an idle bus
    for (int n = 0; n < 8; n++) begin
      restart(n, 1'b0, 1'b0);
      wait_cyc(MRS_AT + 45);
      idx = INIT_REFS + 2;
      r = MRS_AT + spacing(n, T_MRD);
      check("R6 first refresh after mode write", ev_cyc[idx], r);
      check("R6 refresh code with cke high", int'({ev_cmd[idx], ev_cke[idx]}), 3);
      check("R6 spacing one", ev_cyc[idx + 1] - ev_cyc[idx], spacing(n, T_RFC));
      check("R6 spacing two", ev_cyc[idx + 2] - ev_cyc[idx + 1], spacing(n, T_RFC));
      if (n == 7) begin
        r = ev_cyc[idx];
        check("R8 ready low in refresh gap", int'(rdy_h[r + T_RFC - 1]), 0);
        check("R8 ready back after gap", int'(rdy_h[r + T_RFC]), 1);
        check("R8 ready high before deadline", int'(rdy_h[r + n]), 1);
        check("R8 ready low while owed", int'(rdy_h[r + n + 1]), 0);
      end
    end

    // Busy bus across several deadlines
    restart(5, 1'b0, 1'b0);
    wait_cyc(50);
    busy = 1'b1;
    wait_cyc(90);
    busy = 1'b0;
    wait_cyc(110);
    check("R7 one refresh after busy stretch", count_ev(MRS_AT + 1, 97), 1);
    idx = find_ev(91);
    check("R7 refresh on first idle edge", idx >= 0 ? int'(ev_cmd[idx]) : -1, 1);
    check("R7 next refresh spacing", find_ev(91 + spacing(5, T_RFC)) >= 0 ? 1 : 0, 1);
    check("R8 ready low while owed and busy", int'(rdy_h[70]), 0);

    // Self-refresh round trip
    restart(20, 1'b0, 1'b0);
    wait_cyc(50);
    s_in = 1'b1;
    wait_cyc(51);
    s_in = 1'b0;
    wait_cyc(120);
    s_out = 1'b1;
    wait_cyc(121);
    s_out = 1'b0;
    wait_cyc(150);
    idx = find_ev(51);
    check("R9 entry uses refresh code", idx >= 0 ? int'(ev_cmd[idx]) : -1, 1);
    check("R9 cke low on entry", idx >= 0 ? int'(ev_cke[idx]) : -1, 0);
    check("R9 cke held low", int'(cke_h[60]) + int'(cke_h[120]), 0);
    check("R9 no commands in self-refresh", count_ev(52, 120), 0);
    check("R10 cke high on exit edge", int'(cke_h[121]), 1);
    check("R10 no commands during recovery", count_ev(121, 142), 0);
    check("R10 ready low in recovery", int'(rdy_h[121 + T_XSR - 1]), 0);
    check("R10 ready after recovery", int'(rdy_h[121 + T_XSR]), 1);
    check("R10 interval restarted", find_ev(121 + spacing(20, T_XSR)) >= 0 ? 1 : 0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule